// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block is the digital control core of a battery-backed memory supervisor. It sits between a host and an external memory and passes the host's active-low chip enable through to that memory. An external comparator raises a power-fail flag when the main supply drops too far below the battery voltage. While that flag is high, the outgoing enable is forced to a safe level. The safe level depends on a mode pin: in RAM mode the memory is held deselected so it cannot be written, and in ROM mode the enable is pulled low.

The block also keeps track of a serial access to an internal clock store. A host starts the access with a start pulse and ends it with a done pulse. The power-fail flag is brought into the clock domain through a synchronizer. Once the synchronized flag is high, a running access is aborted with a one-cycle pulse and no new access is accepted until power returns.

A registered two-bit source select tells the analog switch what feeds the backup rail. It selects the main supply in normal operation. During power-fail it selects whichever of two batteries the external comparator reports as higher. A battery input tied to ground never wins that comparison.

Top module: `pfg_top`

## Requirements
- R1: With `rom_mode_i`=0 (RAM mode) and `pfail_i`=1, `ce_n_o` is 1 in the same cycle, whatever `ce_n_i` is.
- R2: With `rom_mode_i`=1 (ROM mode) and `pfail_i`=1, `ce_n_o` is 0 in the same cycle, whatever `ce_n_i` is.
- R3: With `pfail_i`=0, `ce_n_o` equals `ce_n_i` combinationally, in either mode.
- R4: `blocked_o` after clock edge n equals the value `pfail_i` had at edge n-1, which is a two-stage synchronizer. It is 0 after reset.
- R5: `abort_o` is high for exactly one cycle, in the cycle after `blocked_o` rises. It is never high two cycles in a row.
- R6: `xfer_active_o` is set by `xfer_start_i` and cleared by `xfer_done_i`, with done taking priority. It is cleared at the same edge at which `abort_o` rises.
- R7: `xfer_start_i` is ignored while `blocked_o` is 1, so `xfer_active_o` cannot rise in the following cycle.
- R8: `src_sel_o` is registered from `blocked_o`. It is 2'b00 (main supply) when `blocked_o` was 0. When `blocked_o` was 1 it is 2'b01 (battery A) if `bat_a_gt_b_i` is 1 and 2'b10 (battery B) if it is 0, and it is re-evaluated on every cycle.
- R9: Synchronous active-high `rst` clears `blocked_o`, `abort_o` and `xfer_active_o`, and sets `src_sel_o` to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_mode_i | input | 1 | 1 = ROM mode, 0 = RAM mode |
| pfail_i | input | 1 | Asynchronous power-fail flag from the comparator |
| ce_n_i | input | 1 | Incoming active-low chip enable |
| bat_a_gt_b_i | input | 1 | 1 when battery A is above battery B |
| xfer_start_i | input | 1 | Pulse requesting a serial access |
| xfer_done_i | input | 1 | Pulse marking normal end of the access |
| ce_n_o | output | 1 | Gated active-low chip enable to the memory |
| src_sel_o | output | 2 | Backup rail source: 00 main, 01 battery A, 10 battery B |
| blocked_o | output | 1 | Synchronized power-fail flag; accesses refused |
| abort_o | output | 1 | One-cycle abort pulse |
| xfer_active_o | output | 1 | Serial access in progress |

## Verification
The enable path is exercised with `ce_n_i` toggling while the power-fail flag is high and low, in both modes. This distinguishes plain pass-through from the RAM forcing level and from the ROM forcing level. Power-fail is applied in several forms: while an access is running, while idle, as a one-cycle glitch, and while reset is asserted. These cases separate the abort timing and the synchronizer delay from the start refusal. The battery comparison input flips during a long power-fail to show that the source select tracks it on every cycle and returns to the main supply afterwards. A long pseudo-random stretch mixes all of these inputs against the cycle-level model.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN  = 2'b00,
    SRC_BAT_A = 2'b01,
    SRC_BAT_B = 2'b10
  } src_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pfg_ce_gate.sv
module pfg_ce_gate (
  input  logic rom_mode_i,
  input  logic pfail_i,
  input  logic ce_n_i,
  output logic ce_n_o
);
  logic forced_level;

  // RAM mode holds the memory deselected; ROM mode pulls the enable low.
  always_comb begin
    forced_level = ~rom_mode_i;
    ce_n_o       = pfail_i ? forced_level : ce_n_i;
  end
endmodule

// File: rtl/pfg_access_ctl.sv
module pfg_access_ctl (
  input  logic clk,
  input  logic rst,
  input  logic pf_sync_i,
  input  logic start_i,
  input  logic done_i,
  output logic abort_o,
  output logic active_o
);
  logic pf_seen_q;
  logic abort_q;
  logic active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_seen_q <= 1'b0;
      abort_q   <= 1'b0;
      active_q  <= 1'b0;
    end else begin
      pf_seen_q <= pf_sync_i;
      abort_q   <= pf_sync_i & ~pf_seen_q;
      if (pf_sync_i)    active_q <= 1'b0;
      else if (done_i)  active_q <= 1'b0;
      else if (start_i) active_q <= 1'b1;
    end
  end

  assign abort_o  = abort_q;
  assign active_o = active_q;
endmodule

// File: rtl/pfg_src_sel.sv
module pfg_src_sel
  import pfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pf_sync_i,
  input  logic       a_gt_b_i,
  output logic [1:0] src_o
);
  src_e src_q;
  src_e src_d;

  always_comb begin
    if (!pf_sync_i)    src_d = SRC_MAIN;
    else if (a_gt_b_i) src_d = SRC_BAT_A;
    else               src_d = SRC_BAT_B;
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_MAIN;
    else     src_q <= src_d;
  end

  assign src_o = src_q;
endmodule

// File: rtl/pfg_top.sv
module pfg_top #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rom_mode_i,
  input  logic       pfail_i,
  input  logic       ce_n_i,
  input  logic       bat_a_gt_b_i,
  input  logic       xfer_start_i,
  input  logic       xfer_done_i,
  output logic       ce_n_o,
  output logic [1:0] src_sel_o,
  output logic       blocked_o,
  output logic       abort_o,
  output logic       xfer_active_o
);
  logic pf_sync;

  pfg_ce_gate u_gate (
    .rom_mode_i (rom_mode_i),
    .pfail_i    (pfail_i),
    .ce_n_i     (ce_n_i),
    .ce_n_o     (ce_n_o)
  );

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pfail_i),
    .q_o (pf_sync)
  );

  pfg_access_ctl u_acc (
    .clk       (clk),
    .rst       (rst),
    .pf_sync_i (pf_sync),
    .start_i   (xfer_start_i),
    .done_i    (xfer_done_i),
    .abort_o   (abort_o),
    .active_o  (xfer_active_o)
  );

  pfg_src_sel u_src (
    .clk       (clk),
    .rst       (rst),
    .pf_sync_i (pf_sync),
    .a_gt_b_i  (bat_a_gt_b_i),
    .src_o     (src_sel_o)
  );

  assign blocked_o = pf_sync;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker (
  input logic       clk,
  input logic       rst,
  input logic       rom_mode_i,
  input logic       pfail_i,
  input logic       ce_n_i,
  input logic       bat_a_gt_b_i,
  input logic       ce_n_o,
  input logic [1:0] src_sel_o,
  input logic       blocked_o,
  input logic       abort_o,
  input logic       xfer_active_o
);
  AST_RAM_FORCE: assert property (@(posedge clk) disable iff (rst)
    (pfail_i && !rom_mode_i) |-> ce_n_o); // R1
  AST_ROM_FORCE: assert property (@(posedge clk) disable iff (rst)
    (pfail_i && rom_mode_i) |-> !ce_n_o); // R2
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    !pfail_i |-> (ce_n_o == ce_n_i)); // R3
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(blocked_o) |-> $past(pfail_i, 2)); // R4
  AST_ABORT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(blocked_o) |=> abort_o); // R5
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o); // R5
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !xfer_active_o); // R6
  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    blocked_o |=> !$rose(xfer_active_o)); // R7
  AST_SRC_MAIN: assert property (@(posedge clk) disable iff (rst)
    !blocked_o |=> (src_sel_o == 2'b00)); // R8
  AST_SRC_BAT: assert property (@(posedge clk) disable iff (rst)
    blocked_o |=> (src_sel_o == ($past(bat_a_gt_b_i) ? 2'b01 : 2'b10))); // R8
endmodule

bind pfg_top pfg_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .rom_mode_i    (rom_mode_i),
  .pfail_i       (pfail_i),
  .ce_n_i        (ce_n_i),
  .bat_a_gt_b_i  (bat_a_gt_b_i),
  .ce_n_o        (ce_n_o),
  .src_sel_o     (src_sel_o),
  .blocked_o     (blocked_o),
  .abort_o       (abort_o),
  .xfer_active_o (xfer_active_o)
);

// File: tb/pfg_top_tb_top.sv
module pfg_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rom_mode_i = 1'b0;
  logic       pfail_i = 1'b0;
  logic       ce_n_i = 1'b1;
  logic       bat_a_gt_b_i = 1'b0;
  logic       xfer_start_i = 1'b0;
  logic       xfer_done_i = 1'b0;
  logic       ce_n_o;
  logic [1:0] src_sel_o;
  logic       blocked_o;
  logic       abort_o;
  logic       xfer_active_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  pfg_top dut_i (
    .clk (clk), .rst (rst), .rom_mode_i (rom_mode_i), .pfail_i (pfail_i),
    .ce_n_i (ce_n_i), .bat_a_gt_b_i (bat_a_gt_b_i),
    .xfer_start_i (xfer_start_i), .xfer_done_i (xfer_done_i),
    .ce_n_o (ce_n_o), .src_sel_o (src_sel_o), .blocked_o (blocked_o),
    .abort_o (abort_o), .xfer_active_o (xfer_active_o)
  );

  // Behavioural reference: history of sampled power-fail values.
  bit pf_hist[$];
  bit m_blk = 0, m_blk_prev = 0, m_abort = 0, m_act = 0;
  int m_src = 0;

  always @(posedge clk) begin
    bit old_blk;
    old_blk = m_blk;
    if (rst) begin
      pf_hist.delete();
      m_blk = 0; m_blk_prev = 0; m_abort = 0; m_act = 0; m_src = 0;
    end else begin
      m_abort = old_blk && !m_blk_prev;
      m_blk_prev = old_blk;
      if (old_blk) m_src = bat_a_gt_b_i ? 1 : 2;
      else         m_src = 0;
      if (old_blk || xfer_done_i) m_act = 0;
      else if (xfer_start_i)      m_act = 1;
      pf_hist.push_back(pfail_i);
      if (pf_hist.size() > 2) void'(pf_hist.pop_front());
      m_blk = (pf_hist.size() == 2) ? pf_hist[0] : 1'b0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!done_run) begin
      bit exp_ce;
      exp_ce = pfail_i ? !rom_mode_i : ce_n_i;
      if (pfail_i && !rom_mode_i) chk("R1 ce_n_o", ce_n_o, exp_ce);
      else if (pfail_i)           chk("R2 ce_n_o", ce_n_o, exp_ce);
      else                        chk("R3 ce_n_o", ce_n_o, exp_ce);
      chk("R4/R9 blocked_o", blocked_o, m_blk);
      chk("R5/R9 abort_o", abort_o, m_abort);
      chk("R6/R7/R9 xfer_active_o", xfer_active_o, m_act);
      chk("R8/R9 src_sel_o", src_sel_o, m_src);
    end
  end

  task automatic step(bit rm, bit pf, bit ce, bit ab, bit st, bit dn);
    @(posedge clk); #1;
    rom_mode_i = rm; pfail_i = pf; ce_n_i = ce;
    bat_a_gt_b_i = ab; xfer_start_i = st; xfer_done_i = dn;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
      begin
        // R9 reset state checked by the per-cycle compare
        repeat (3) step(0, 0, 1, 0, 0, 0);
        @(posedge clk); #1 rst = 0;
        // R3 pass-through in both modes
        for (int i = 0; i < 8; i++) step(i[2], 0, i[0], 0, 0, 0);
        // R6 start then done
        step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, 0);
        // R1 R5 R6 R8: RAM power-fail during access, battery flip
        for (int i = 0; i < 10; i++) step(0, 1, i[0], i[1], i == 5, 0);
        // R7 start while blocked
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 1, 0);
        for (int i = 0; i < 4; i++) step(0, 0, i[0], 0, 0, 0);
        // R2 ROM power-fail
        for (int i = 0; i < 6; i++) step(1, 1, i[0], 1, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 0, i[0], 1, 0, 0);
        // R4 one-cycle glitch
        step(0, 0, 0, 0, 1, 0); step(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0);
        // R9 power-fail held across reset
        step(0, 1, 0, 1, 0, 0); rst = 1;
        step(0, 1, 0, 1, 0, 0); step(0, 1, 0, 1, 0, 0);
        rst = 0;
        for (int i = 0; i < 5; i++) step(0, 1, 0, 1, 0, 0);
        // Pseudo-random mix
        begin
          logic [15:0] lfsr = 16'hACE1;
          for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3], lfsr[7] & lfsr[8], lfsr[0], lfsr[5],
                 lfsr[2], lfsr[9] & lfsr[11]);
          end
        end
        step(0, 0, 1, 0, 0, 0);
        @(negedge clk); @(posedge clk);
      end
    join_any
    done_run = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule